// File: doc/BRIEF.md
# Oversampled I2C Slave Output Expander

This block is an I2C slave that gives a bus master eight general-purpose output pins. It does not use SCL as a clock. Instead it samples both bus lines on a fast system clock. Each line passes through a two-flop synchronizer and then a digital filter that rejects short pulses. START and STOP are found from edges of the cleaned-up lines. The slave answers one fixed 7-bit address, set by a parameter with default 0x27.

A write transaction loads a byte into an internal 8-bit register, and that register drives the output pins. A read transaction returns the register over SDA. SDA is open-drain: the block only has a drive-low enable and never drives the line high. Every change of that enable is made a few system clocks after the filtered SCL falls, so the slave can never produce a false START or STOP. If the master answers a read byte with NACK, the slave stays off the bus until the next START.

Top module: `i2c_io_expander`

## Requirements
- R1: While reset is high, and right after it is released, `gpio_o` is 0x00 and `sda_drive_low_o` is 0 (line released).
- R2: When the seven address bits, sent MSB first after START, equal the address parameter, the slave pulls SDA low in the ninth (acknowledge) slot of the address byte. This holds for both values of the eighth bit, where 1 means read and 0 means write.
- R3: In a matched write, each data byte is received MSB first and acknowledged in its ninth slot. `gpio_o` takes the full byte only once its eighth bit has been sampled on a rising SCL.
- R4: If any address bit differs from the parameter, the slave never drives SDA for the rest of that transaction, and `gpio_o` is left unchanged.
- R5: In a matched read, the slave sends the register MSB first. It pulls SDA low for 0 bits and releases it for 1 bits. It leaves the acknowledge slot of every data byte released.
- R6: Once the master answers a read byte with NACK (SDA high in the ninth slot), the slave keeps SDA released for every later bit until the next START.
- R7: A pulse on SCL or SDA that lasts fewer than the filter length in system clocks (default 3) has no effect on the protocol. Such a pulse on SCL does not count as a bit, and such a pulse on SDA while SCL is high is not taken as START or STOP.
- R8: A START, including a repeated START in the middle of a byte, returns the slave to the first address bit. A partly received data byte is then dropped.
- R9: `sda_drive_low_o` changes only while the filtered SCL is low.
- R10: In a write of several data bytes, each byte is acknowledged and `gpio_o` holds the last complete byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_drive_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| gpio_o | output | 8 | Register contents driving the output pins |

## Verification
The hardest cases to reach from the ports are the ones where protocol state must be cut off or kept alive in the middle of a byte. The bench covers these directly. It sends a repeated START after only four data bits. It injects SCL and SDA pulses just shorter than the filter window, placed inside the low and high phases of chosen bits. It runs a read in which the master acknowledges one byte and then NACKs the next. To make released slots visible, the bench models the open-drain wire as the AND of the master's level and the slave's inverted enable. It then watches the enable itself across whole transactions, so a missing drive and an unwanted drive are both seen at the ports.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic scl;
    logic sda;
  } i2cx_lines_t;
endpackage

// File: rtl/i2cx_line_filter.sv
module i2cx_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter bit IDLE_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{IDLE_VAL}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], d_i};
  end

  // a new level is accepted only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o     <= IDLE_VAL;
      run_cnt <= '0;
    end else if (sync_q[SYNC_STAGES-1] == q_o) begin
      run_cnt <= '0;
    end else if (run_cnt == CW'(FILT_LEN - 1)) begin
      q_o     <= sync_q[SYNC_STAGES-1];
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2cx_cond_detect.sv
module i2cx_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise  = scl_f & ~scl_q;
    scl_fall  = ~scl_f & scl_q;
    start_det = scl_f & scl_q & sda_q & ~sda_f;
    stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  end
endmodule

// File: rtl/i2cx_bit_engine.sv
module i2cx_bit_engine #(
  parameter logic [i2cx_pkg::ADDR_W-1:0] SLAVE_ADDR = 7'h27,
  parameter int DW = i2cx_pkg::BYTE_W,
  parameter int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_f,
  output logic [DW-1:0] reg_q,
  output logic          want_low,
  output logic [CW-1:0] bit_cnt,
  output logic          addr_match
);
  localparam int AW = i2cx_pkg::ADDR_W;
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic          in_xfer, data_ph, rd_op, m_ack, seen_rise;
  logic [DW-1:0] shf;
  logic [IW-1:0] rd_idx;
  logic          rd_bit;
  logic          addr_bit;

  always_comb begin
    rd_idx   = IW'(DW - 1 - int'(bit_cnt));
    rd_bit   = (bit_cnt < ACK_SLOT) ? reg_q[rd_idx] : 1'b1;
    addr_bit = (bit_cnt < CW'(AW)) ? SLAVE_ADDR[AW - 1 - int'(bit_cnt)] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_xfer    <= 1'b0;
      data_ph    <= 1'b0;
      addr_match <= 1'b0;
      rd_op      <= 1'b0;
      m_ack      <= 1'b0;
      seen_rise  <= 1'b0;
      bit_cnt    <= '0;
      shf        <= '0;
      reg_q      <= '0;
    end else if (start_det || stop_det) begin
      in_xfer    <= start_det;
      data_ph    <= 1'b0;
      addr_match <= 1'b1;
      rd_op      <= 1'b0;
      m_ack      <= 1'b0;
      seen_rise  <= 1'b0;
      bit_cnt    <= '0;
    end else if (in_xfer) begin
      if (scl_rise) begin
        seen_rise <= 1'b1;
        if (bit_cnt == ACK_SLOT) begin
          // address ACK seeds the flag; a data NACK clears it until next START
          if (!data_ph) m_ack <= ~sda_f;
          else          m_ack <= m_ack & ~sda_f;
        end else if (!data_ph) begin
          if (bit_cnt == LAST_BIT)   rd_op <= sda_f;
          else if (sda_f != addr_bit) addr_match <= 1'b0;
        end else begin
          shf <= {shf[DW-2:0], sda_f};
          if (bit_cnt == LAST_BIT && addr_match && !rd_op)
            reg_q <= {shf[DW-2:0], sda_f};
        end
      end
      if (scl_fall && seen_rise) begin
        if (bit_cnt == ACK_SLOT) begin
          bit_cnt <= '0;
          data_ph <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    want_low = 1'b0;
    if (in_xfer && addr_match) begin
      if (bit_cnt == ACK_SLOT)
        want_low = !data_ph || !rd_op;
      else if (data_ph && rd_op)
        want_low = m_ack && !rd_bit;
    end
  end
endmodule

// File: rtl/i2cx_sda_driver.sv
module i2cx_sda_driver #(
  parameter int DRIVE_DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_fall,
  input  logic scl_f,
  input  logic want_low,
  output logic drive_low
);
  localparam int CW = $clog2(DRIVE_DELAY + 1);

  logic [CW-1:0] dly;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly       <= '0;
      pend      <= 1'b0;
      drive_low <= 1'b0;
    end else if (scl_fall) begin
      pend <= 1'b1;
      dly  <= CW'(DRIVE_DELAY);
    end else if (pend) begin
      if (scl_f) begin
        pend <= 1'b0;
      end else if (dly == '0) begin
        drive_low <= want_low;
        pend      <= 1'b0;
      end else begin
        dly <= dly - 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_io_expander.sv
module i2c_io_expander #(
  parameter logic [6:0] SLAVE_ADDR  = 7'h27,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         DRIVE_DELAY = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_low_o,
  output logic [7:0] gpio_o
);
  import i2cx_pkg::*;
  localparam int CW = $clog2(BYTE_W + 1);

  i2cx_lines_t raw, flt;
  logic scl_rise, scl_fall, start_det, stop_det, want_low, addr_match;
  logic [CW-1:0] bit_cnt;
  logic scl_flt;

  assign raw.scl = scl_i;
  assign raw.sda = sda_i;
  assign scl_flt = flt.scl;

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2cx_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .IDLE_VAL   (1'b1)
    ) filt_i (
      .clk(clk),
      .rst(rst),
      .d_i(raw[g]),
      .q_o(flt[g])
    );
  end

  i2cx_cond_detect cond_i (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (flt.scl),
    .sda_f    (flt.sda),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cx_bit_engine #(
    .SLAVE_ADDR(SLAVE_ADDR),
    .DW        (BYTE_W),
    .CW        (CW)
  ) eng_i (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_f     (flt.sda),
    .reg_q     (gpio_o),
    .want_low  (want_low),
    .bit_cnt   (bit_cnt),
    .addr_match(addr_match)
  );

  i2cx_sda_driver #(
    .DRIVE_DELAY(DRIVE_DELAY)
  ) drv_i (
    .clk      (clk),
    .rst      (rst),
    .scl_fall (scl_fall),
    .scl_f    (flt.scl),
    .want_low (want_low),
    .drive_low(sda_drive_low_o)
  );
endmodule

// File: rtl/i2c_io_expander_chk.sv
module i2c_io_expander_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_f,
  input logic          start_det,
  input logic          stop_det,
  input logic [CW-1:0] bit_cnt,
  input logic          addr_match,
  input logic          sda_drive_low_o,
  input logic [7:0]    gpio_o
);
  // R1
  a_r1_reset_release: assert property (@(posedge clk)
    rst |=> (!sda_drive_low_o && gpio_o == 8'h00));

  // R9
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drive_low_o) |-> !scl_f);

  // R3
  a_r3_gpio_on_scl_high: assert property (@(posedge clk) disable iff (rst)
    !$stable(gpio_o) |-> scl_f);

  // R8
  a_r8_cond_restarts: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |=> (bit_cnt == '0 && addr_match));

  // R4
  a_r4_no_drive_unmatched: assert property (@(posedge clk) disable iff (rst)
    (!addr_match && $past(!addr_match)) |-> !$rose(sda_drive_low_o));
endmodule

bind i2c_io_expander i2c_io_expander_chk #(.CW(CW)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .scl_f          (scl_flt),
  .start_det      (start_det),
  .stop_det       (stop_det),
  .bit_cnt        (bit_cnt),
  .addr_match     (addr_match),
  .sda_drive_low_o(sda_drive_low_o),
  .gpio_o         (gpio_o)
);

// File: tb/i2c_io_expander_tb.sv
module i2c_io_expander_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;
  localparam logic [6:0] MY_ADDR = 7'h27;
  localparam int NVEC = 6;
  // each entry: {address[14:8], data[7:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {7'h27, 8'hA5}, {7'h27, 8'h3C}, {7'h26, 8'hFF},
    {7'h27, 8'h00}, {7'h67, 8'h55}, {7'h27, 8'h81}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_drive_low_o;
  logic [7:0] gpio_o;
  logic sda_line;

  int n_vec = 0;
  int n_bad = 0;
  logic mon_en = 1'b0;
  logic saw_drive = 1'b0;
  logic slot_drive;
  logic glitch_scl = 1'b0;
  logic glitch_sda = 1'b0;
  logic [7:0] exp_gpio = 8'h00;

  assign sda_line = m_sda & ~sda_drive_low_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_io_expander dut_i (
    .clk            (clk),
    .rst            (rst),
    .scl_i          (m_scl),
    .sda_i          (sda_line),
    .sda_drive_low_o(sda_drive_low_o),
    .gpio_o         (gpio_o)
  );

  always @(negedge clk) if (mon_en && sda_drive_low_o) saw_drive <= 1'b1;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wclk(Q);
    m_scl = 1'b1; wclk(Q);
    m_sda = 1'b0; wclk(Q);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wclk(Q);
    m_scl = 1'b1; wclk(Q);
    m_sda = 1'b1; wclk(2*Q);
  endtask

  // entered and left with SCL low
  task automatic i2c_bit(input logic b, output logic s);
    m_sda = b;
    if (glitch_scl) begin
      wclk(5); m_scl = 1'b1; wclk(2); m_scl = 1'b0; wclk(Q - 7);
    end else begin
      wclk(Q);
    end
    m_scl = 1'b1; wclk(Q);
    s = sda_line;
    slot_drive = sda_drive_low_o;
    if (glitch_sda && b) begin
      m_sda = 1'b0; wclk(2); m_sda = 1'b1; wclk(Q - 2);
    end else begin
      wclk(Q);
    end
    m_scl = 1'b0; wclk(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) i2c_bit(b[i], s);
    i2c_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v, output logic ack_slot_drv);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      i2c_bit(1'b1, s);
      v[i] = s;
    end
    i2c_bit(~give_ack, s);
    ack_slot_drv = slot_drive;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic ack, ack2, drv;
    logic [7:0] rv;
    wclk(5);
    // R1: held in reset, then just after release
    chk("R1 gpio in reset", gpio_o, 8'h00);
    chk("R1 sda released in reset", {7'b0, sda_drive_low_o}, 8'h00);
    rst = 1'b0;
    wclk(3);
    chk("R1 gpio after reset", gpio_o, 8'h00);
    chk("R1 sda after reset", {7'b0, sda_drive_low_o}, 8'h00);

    // table walk: write, then read back with NACK
    for (int v = 0; v < NVEC; v++) begin
      logic hit;
      hit = (VEC[v][14:8] == MY_ADDR);
      saw_drive = 1'b0; mon_en = 1'b1;
      i2c_start();
      send_byte({VEC[v][14:8], 1'b0}, ack);
      chk(hit ? "R2 address ack" : "R4 no ack on mismatch", {7'b0, ack}, {7'b0, hit});
      send_byte(VEC[v][7:0], ack2);
      i2c_stop();
      mon_en = 1'b0;
      if (hit) begin
        exp_gpio = VEC[v][7:0];
        chk("R3 data ack", {7'b0, ack2}, 8'h01);
      end else begin
        chk("R4 never drove", {7'b0, saw_drive}, 8'h00);
      end
      chk("R3/R4 gpio after write", gpio_o, exp_gpio);
      i2c_start();
      send_byte({MY_ADDR, 1'b1}, ack);
      chk("R2 read address ack", {7'b0, ack}, 8'h01);
      recv_byte(1'b0, rv, drv);
      chk("R5 read data", rv, exp_gpio);
      chk("R5 data ack slot released", {7'b0, drv}, 8'h00);
      i2c_stop();
    end

    // R6: ACK first byte, NACK second, slave silent on third
    i2c_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    recv_byte(1'b1, rv, drv);
    chk("R5 first of two reads", rv, exp_gpio);
    recv_byte(1'b0, rv, drv);
    chk("R5 second read", rv, exp_gpio);
    saw_drive = 1'b0; mon_en = 1'b1;
    recv_byte(1'b0, rv, drv);
    mon_en = 1'b0;
    chk("R6 released after NACK", rv, 8'hFF);
    chk("R6 no drive after NACK", {7'b0, saw_drive}, 8'h00);
    i2c_stop();

    // R10: multi-byte write
    i2c_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    send_byte(8'h11, ack);  chk("R10 ack byte 1", {7'b0, ack}, 8'h01);
    send_byte(8'h22, ack);  chk("R10 ack byte 2", {7'b0, ack}, 8'h01);
    chk("R3 gpio mid-transaction", gpio_o, 8'h22);
    send_byte(8'h33, ack);  chk("R10 ack byte 3", {7'b0, ack}, 8'h01);
    i2c_stop();
    chk("R10 last byte wins", gpio_o, 8'h33);

    // R8: repeated START after four data bits
    i2c_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    for (int i = 0; i < 4; i++) i2c_bit(1'b1, ack2);
    i2c_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    chk("R8 ack after restart", {7'b0, ack}, 8'h01);
    send_byte(8'h96, ack);
    i2c_stop();
    chk("R8 byte after restart", gpio_o, 8'h96);

    // R7: sub-filter pulses on both lines
    i2c_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    glitch_scl = 1'b1; glitch_sda = 1'b1;
    send_byte(8'h5A, ack);
    glitch_scl = 1'b0; glitch_sda = 1'b0;
    i2c_stop();
    chk("R7 ack despite pulses", {7'b0, ack}, 8'h01);
    chk("R7 gpio despite pulses", gpio_o, 8'h5A);

    // R4: read to a foreign address leaves bus untouched
    saw_drive = 1'b0; mon_en = 1'b1;
    i2c_start();
    send_byte({7'h28, 1'b1}, ack);
    recv_byte(1'b0, rv, drv);
    i2c_stop();
    mon_en = 1'b0;
    chk("R4 foreign read no drive", {7'b0, saw_drive}, 8'h00);
    chk("R4 foreign read gpio kept", gpio_o, 8'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule